// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block sits in the feedback path of a frequency synthesizer. It divides a fast input clock, taken from the oscillator, down to the comparison rate that a phase detector expects. It produces a single-cycle pulse once per division period. A 16-bit divide word and a 2-bit mode input set the ratio. Three kinds of operation are available. In the two swallow modes, a dual-modulus 32/33 prescaler is steered by a 5-bit swallow count A and an 11-bit main count B. In direct mode, one 16-bit counter C divides the input on its own. In standby, nothing counts.

The divide word and mode are captured into a holding register only when a division period completes, or at any edge while the block is idle in standby. Software can therefore rewrite them at any moment without producing a shortened or stretched output period. The prescaler is modelled as ordinary logic clocked by the same input clock. Both swallow encodings drive the same engine. The interface is plain control and status, with no flow control: the input clock always advances the division.

Top module: `swallow_divider`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `div_pulse` and `cfg_err` are low and the block is in standby.
- R2: With `op_mode` = 2'b10, A is `div_word[4:0]` and B is `div_word[15:5]`. The prescaler divides by 33 for the first A prescaler cycles and by 32 for the remaining B+1−A cycles. The output period is therefore 32·B + A + 32 input clocks.
- R3: `op_mode` = 2'b11 gives exactly the same division as 2'b10 for the same divide word.
- R4: With `op_mode` = 2'b01, the output period is C+1 input clocks, where C is all 16 bits of `div_word`. C = 0 gives a pulse on every clock.
- R5: With `op_mode` = 2'b00, no pulse is produced once the current period has finished, and `cfg_err` is low. While idle, the held divide word is forced to 16'hEFEF.
- R6: The swallow modes are legal only when A ≤ B. With a 5-bit A, the limit A ≤ 32 always holds.
- R7: `cfg_err` is high exactly while a swallow configuration with B < A is in effect. It is never high in direct mode or standby.
- R8: A change to `div_word` or `op_mode` in the middle of a period does not alter that period. The new setting governs the following periods.
- R9: When the period is longer than one clock, each pulse lasts one clock. Exactly one pulse marks the end of each period.
- R10: When the block leaves standby, the first pulse appears after N rising edges, where N is the period of the new setting. The edge that captures the new mode counts as the first of these.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fin_clk | input | 1 | Oscillator-derived input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| div_word | input | 16 | Divide word: A and B fields in swallow modes, C in direct mode |
| op_mode | input | 2 | 00 standby, 01 direct, 10 and 11 swallow |
| div_pulse | output | 1 | One-clock pulse at the end of each division period |
| cfg_err | output | 1 | High while a held swallow setting breaks the rule A ≤ B |

## Verification
The bench measures the gap between consecutive pulses at several corners:
- **Zero counts in swallow mode (A = 0, B = 0).** A prescaler that miscounts its modulus would be off by a cycle here.
- **A = B = 31.** A design that swaps the 33 and 32 phases, or mis-slices the fields, would miss 1055.
- **Direct C = 0 and C = 1.** An off-by-one terminal compare would lose the every-cycle pulse.
- **Settings rewritten mid-period.** A design that loads immediately would emit a truncated period instead of the remaining count.
- **Leaving standby.** This exposes an extra idle cycle at start-up.
- **Entering standby.** A design that keeps counting would show a stray pulse.
- **An illegal B < A setting.** This must raise the error flag, and the flag must drop once a legal setting takes over.

// File: rtl/psd_pkg.sv
package psd_pkg;
  typedef enum logic [1:0] {
    MD_STBY   = 2'b00,
    MD_DIRECT = 2'b01,
    MD_AMSW   = 2'b10,
    MD_FMSW   = 2'b11
  } psd_mode_e;
endpackage

// File: rtl/psd_ctrl.sv
module psd_ctrl
  import psd_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter logic [WORD_W-1:0] STBY_FILL = {(WORD_W/8){8'hEF}}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_in,
  input  logic [1:0]        mode_in,
  input  logic              period_end,
  output logic [WORD_W-1:0] word_q,
  output psd_mode_e         mode_q,
  output logic              restart
);
  psd_mode_e mode_nxt;

  assign mode_nxt = psd_mode_e'(mode_in);
  // capture only when idle or when a period has just closed
  assign restart  = (mode_q == MD_STBY) || period_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_STBY;
      word_q <= STBY_FILL;
    end else if (restart) begin
      mode_q <= mode_nxt;
      word_q <= (mode_nxt == MD_STBY) ? STBY_FILL : word_in;
    end
  end

  // R8
  hold_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    !restart |=> ($stable(word_q) && $stable(mode_q)));

  // R5
  stby_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_STBY) |-> (word_q == STBY_FILL));
endmodule

// File: rtl/psd_direct.sv
module psd_direct #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              restart,
  input  logic [WORD_W-1:0] c_val,
  output logic              term
);
  logic [WORD_W-1:0] cnt;

  assign term = en && (cnt == c_val);

  always_ff @(posedge clk) begin
    if (rst || restart || !en) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  // R4
  cnt_le_c_chk: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt <= c_val));
endmodule

// File: rtl/psd_swallow.sv
module psd_swallow #(
  parameter int SWALLOW_W = 5,
  parameter int MAIN_W    = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 restart,
  input  logic [SWALLOW_W-1:0] a_val,
  input  logic [MAIN_W-1:0]    b_val,
  output logic                 term
);
  localparam int PRESC_MOD = 1 << SWALLOW_W;
  localparam logic [SWALLOW_W:0] LAST_HI = (SWALLOW_W+1)'(PRESC_MOD);
  localparam logic [SWALLOW_W:0] LAST_LO = (SWALLOW_W+1)'(PRESC_MOD - 1);

  logic [SWALLOW_W:0]   pre_cnt;
  logic [SWALLOW_W-1:0] s_cnt;
  logic [MAIN_W-1:0]    b_cnt;
  logic                 wide_mod;
  logic                 tick;

  // divide by PRESC_MOD+1 until A prescaler cycles have been swallowed
  assign wide_mod = (s_cnt < a_val);
  assign tick     = (pre_cnt == (wide_mod ? LAST_HI : LAST_LO));
  assign term     = en && tick && (b_cnt == b_val);

  always_ff @(posedge clk) begin
    if (rst || restart || !en) begin
      pre_cnt <= '0;
      s_cnt   <= '0;
      b_cnt   <= '0;
    end else if (tick) begin
      pre_cnt <= '0;
      b_cnt   <= b_cnt + 1'b1;
      if (wide_mod) s_cnt <= s_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  // R2
  swallow_bound_chk: assert property (@(posedge clk) disable iff (rst)
    en |-> (s_cnt <= a_val));

  // R2
  presc_range_chk: assert property (@(posedge clk) disable iff (rst)
    en |-> (pre_cnt <= LAST_HI));

  // R2
  main_bound_chk: assert property (@(posedge clk) disable iff (rst)
    en |-> (b_cnt <= b_val));
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import psd_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int SWALLOW_W = 5
) (
  input  logic              fin_clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] div_word,
  input  logic [1:0]        op_mode,
  output logic              div_pulse,
  output logic              cfg_err
);
  localparam int MAIN_W = WORD_W - SWALLOW_W;
  localparam logic [WORD_W-1:0] STBY_FILL = {(WORD_W/8){8'hEF}};

  logic [WORD_W-1:0]    word_q;
  psd_mode_e            mode_q;
  logic                 restart;
  logic                 sw_en, dir_en;
  logic                 sw_term, dir_term;
  logic [SWALLOW_W-1:0] a_val;
  logic [MAIN_W-1:0]    b_val;

  assign a_val  = word_q[SWALLOW_W-1:0];
  assign b_val  = word_q[WORD_W-1:SWALLOW_W];
  assign sw_en  = (mode_q == MD_AMSW) || (mode_q == MD_FMSW);
  assign dir_en = (mode_q == MD_DIRECT);

  psd_ctrl #(.WORD_W(WORD_W), .STBY_FILL(STBY_FILL)) ctrl_i (
    .clk(fin_clk), .rst(rst), .word_in(div_word), .mode_in(op_mode),
    .period_end(div_pulse), .word_q(word_q), .mode_q(mode_q), .restart(restart)
  );

  psd_swallow #(.SWALLOW_W(SWALLOW_W), .MAIN_W(MAIN_W)) swallow_i (
    .clk(fin_clk), .rst(rst), .en(sw_en), .restart(restart),
    .a_val(a_val), .b_val(b_val), .term(sw_term)
  );

  psd_direct #(.WORD_W(WORD_W)) direct_i (
    .clk(fin_clk), .rst(rst), .en(dir_en), .restart(restart),
    .c_val(word_q), .term(dir_term)
  );

  assign div_pulse = sw_term || dir_term;
  assign cfg_err   = sw_en && (b_val < MAIN_W'(a_val));

  // R5
  stby_quiet_chk: assert property (@(posedge fin_clk) disable iff (rst)
    (mode_q == MD_STBY) |-> !div_pulse);

  // R7
  err_mode_chk: assert property (@(posedge fin_clk) disable iff (rst)
    cfg_err |-> sw_en);

  // R9
  single_src_chk: assert property (@(posedge fin_clk) disable iff (rst)
    $onehot0({sw_term, dir_term}));
endmodule

// File: tb/swallow_divider_tb_top.sv
module swallow_divider_tb_top;
  logic        fin_clk = 1'b0;
  logic        rst;
  logic [15:0] div_word;
  logic [1:0]  op_mode;
  logic        div_pulse;
  logic        cfg_err;
  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #5 fin_clk = ~fin_clk;

  swallow_divider dut_i (
    .fin_clk(fin_clk), .rst(rst), .div_word(div_word), .op_mode(op_mode),
    .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  function automatic int exp_sw(logic [15:0] w);
    return 32 * int'(w[15:5]) + int'(w[4:0]) + 32;
  endfunction

  function automatic int exp_dir(logic [15:0] w);
    return int'(w) + 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge fin_clk);
    @(negedge fin_clk);
  endtask

  task automatic next_gap(output int g);
    g = 0;
    do begin
      step();
      g++;
    end while (!div_pulse && g < 70000);
  endtask

  task automatic run_cfg(input logic [1:0] m, input logic [15:0] w,
                         input int n, input string req);
    int g;
    op_mode  = m;
    div_word = w;
    next_gap(g);
    next_gap(g);
    check(g == n, req, g, n);
    next_gap(g);
    check(g == n, req, g, n);
  endtask

  always @(posedge fin_clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int g;
    int pc;
    void'($urandom(32'd20240));
    rst = 1'b1; op_mode = 2'b00; div_word = 16'h0000;
    repeat (3) @(posedge fin_clk);
    @(negedge fin_clk);
    check(!div_pulse && !cfg_err, "R1", {div_pulse, cfg_err}, 0);
    rst = 1'b0;
    step();
    check(!div_pulse && !cfg_err, "R1", {div_pulse, cfg_err}, 0);

    // R5: idle from reset, word ignored
    div_word = 16'h1234;
    pc = 0;
    for (int i = 0; i < 300; i++) begin step(); if (div_pulse) pc++; end
    check(pc == 0, "R5", pc, 0);

    // R10: leave standby into direct C=6
    op_mode = 2'b01; div_word = 16'd6;
    next_gap(g);
    check(g == 7, "R10", g, 7);

    // R4 corners
    run_cfg(2'b01, 16'd0, 1, "R4");
    run_cfg(2'b01, 16'd1, 2, "R4");
    check(!cfg_err, "R7", cfg_err, 0);

    // R9: pulse one clock wide
    run_cfg(2'b01, 16'd4, 5, "R9");
    step();
    check(!div_pulse, "R9", div_pulse, 0);

    // R2 corners
    run_cfg(2'b10, {11'd0, 5'd0}, 32, "R2");
    run_cfg(2'b10, {11'd31, 5'd31}, 1055, "R2");
    run_cfg(2'b10, {11'd100, 5'd0}, 3232, "R2");

    // R3: both swallow encodings match
    run_cfg(2'b11, {11'd20, 5'd7}, 679, "R3");
    run_cfg(2'b10, {11'd20, 5'd7}, 679, "R3");

    // R7 / R6: illegal B < A
    op_mode = 2'b10; div_word = {11'd2, 5'd5};
    next_gap(g);
    step();
    check(cfg_err == 1'b1, "R7", cfg_err, 1);
    div_word = {11'd9, 5'd5};
    next_gap(g);
    step();
    check(cfg_err == 1'b0, "R6", cfg_err, 0);

    // R8: mid-period rewrite
    run_cfg(2'b01, 16'd9, 10, "R8");
    repeat (3) step();
    div_word = 16'd20;
    next_gap(g);
    check(g == 7, "R8", g, 7);
    next_gap(g);
    check(g == 21, "R8", g, 21);
    repeat (4) step();
    op_mode = 2'b10; div_word = {11'd1, 5'd1};
    next_gap(g);
    check(g == 17, "R8", g, 17);
    next_gap(g);
    check(g == 65, "R8", g, 65);

    // R5: enter standby from an active mode
    op_mode = 2'b00;
    next_gap(g);
    pc = 0;
    for (int i = 0; i < 200; i++) begin step(); if (div_pulse || cfg_err) pc++; end
    check(pc == 0, "R5", pc, 0);

    // R10: leave standby into swallow
    op_mode = 2'b10; div_word = {11'd3, 5'd2};
    next_gap(g);
    check(g == 130, "R10", g, 130);

    // random swallow settings (R2, R3)
    for (int k = 0; k < 8; k++) begin
      logic [4:0]  a;
      logic [10:0] b;
      logic [1:0]  m;
      a = 5'($urandom % 32);
      b = 11'(int'(a) + int'($urandom % 40));
      m = 2'b10 | 2'($urandom % 2);
      run_cfg(m, {b, a}, exp_sw({b, a}), "R2");
      check(!cfg_err, "R7", cfg_err, 0);
    end

    // random direct settings (R4)
    for (int k = 0; k < 6; k++) begin
      logic [15:0] c;
      c = 16'($urandom % 500);
      run_cfg(2'b01, c, exp_dir(c), "R4");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule